// File: doc/BRIEF.md
# I/O MMU control and interrupt register block

This block is the software-facing control plane of a small two-level I/O MMU. It holds the page-directory base address and accepts one-shot command writes that switch address translation on or off, pause (stall) the translation datapath, flush every cached translation, acknowledge a page fault and return the whole block to its reset state. It drives the paging and stall controls and the cache-flush pulses into the translation datapath. It takes page-fault and bus-error events back from the datapath, along with the faulting address and the access direction.

Events are latched in a raw interrupt register. A mask register selects which raw bits can reach the interrupt line, and software acknowledges events by writing ones to a clear register. The paging, stall and reset commands take effect a fixed `CMD_LAT` cycles after the write, through a short command pipeline. The flush, flush-one-line and fault-acknowledge commands act on the next clock edge. Reads are combinational from the address.

Top module: `iommu_ctl_regs`

## Requirements
- R1: Registers decode at these byte offsets: 0x00 directory base, 0x04 status, 0x08 command (write-only), 0x0C fault address, 0x10 flush one line (write-only), 0x14 raw interrupts, 0x18 interrupt clear (write-only), 0x1C interrupt mask, 0x20 masked interrupts, 0x24 clock-gating configuration. After reset every readable register reads 0 except status.
- R2: The directory base keeps only bits 31:12 of a write, and bits 11:0 read as zero. For example, writing 0xCAFEBABE reads back 0xCAFEB000.
- R3: Command 0 sets paging and command 1 clears it. Either change appears on `paging_en_o` and status bit 0 exactly `CMD_LAT` clock edges after the edge that samples the write.
- R4: Command 2 sets stall only if paging is on when the command takes effect. Command 3 clears stall, and clearing paging also clears stall. Status bit 2 shows stall and status bit 31 always reads as its inverse.
- R5: Command 4 makes `zap_all_o` high for exactly one cycle, following the edge that samples the write.
- R6: A write to offset 0x10 makes `zap_line_o` high for one cycle, with `zap_line_addr_o` holding the written value with bits 11:0 cleared.
- R7: A page-fault event sets raw bit 0 and status bit 1 (fault active), stores the access direction in status bit 5 (1 = write), and captures the address at 0x0C. A bus-error event sets raw bit 1 and captures the address, leaving status bit 5 unchanged.
- R8: The masked register reads raw AND mask (2 bits), and `irq_o` is high exactly when that value is nonzero.
- R9: Writing ones to the clear register clears the matching raw bits. An event arriving in the same cycle as its clear leaves the bit set.
- R10: Command 5 clears status bit 1 on the next edge and leaves the raw bits alone. A page-fault event in the same cycle keeps the bit set.
- R11: Command 6, once it takes effect after `CMD_LAT` edges, zeroes the directory base, paging, stall, mask, raw bits, fault-active and fault-direction bits, fault address and gating configuration.
- R12: Status bits 3 and 4 mirror `dp_idle_i` and `dp_replay_empty_i`. Write-only and unmapped offsets read 0. Command values of 7 or more, compared over all 32 bits, change nothing.
- R13: The gating register stores the low `GATE_W` bits of a write, reads them back and drives them on `gate_cfg_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` (combinational) |
| dp_fault_i | input | 1 | Page-fault event from the datapath (one cycle) |
| dp_bus_err_i | input | 1 | Bus-error event from the datapath (one cycle) |
| dp_fault_write_i | input | 1 | Faulting access was a write |
| dp_fault_addr_i | input | DATA_W | Address of the faulting access |
| dp_idle_i | input | 1 | Datapath idle |
| dp_replay_empty_i | input | 1 | Datapath replay buffer empty |
| paging_en_o | output | 1 | Translation enabled |
| stall_en_o | output | 1 | Datapath stall request |
| zap_all_o | output | 1 | Flush the whole translation cache (pulse) |
| zap_line_o | output | 1 | Flush one cached translation (pulse) |
| zap_line_addr_o | output | DATA_W | Page address of the line to flush |
| gate_cfg_o | output | GATE_W | Clock-gating configuration |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in one cycle: a raw-interrupt clear with a new event on the same bit, and a fault acknowledge with a new page fault. The bench provokes each pair by raising the event input on the same clock edge that samples the register write. In both cases it judges the result by reading the raw bit or the fault-active status bit afterwards, and expects the event to win. It also checks that a stall command takes no effect while paging is off and that turning paging off drops an active stall.

// File: rtl/iommu_ctl_pkg.sv
package iommu_ctl_pkg;

   // register byte offsets
   localparam logic [7:0] OFF_BASE  = 8'h00;
   localparam logic [7:0] OFF_STAT  = 8'h04;
   localparam logic [7:0] OFF_CMD   = 8'h08;
   localparam logic [7:0] OFF_FADDR = 8'h0C;
   localparam logic [7:0] OFF_ZAPLN = 8'h10;
   localparam logic [7:0] OFF_RAW   = 8'h14;
   localparam logic [7:0] OFF_CLR   = 8'h18;
   localparam logic [7:0] OFF_MASK  = 8'h1C;
   localparam logic [7:0] OFF_MSTAT = 8'h20;
   localparam logic [7:0] OFF_GATE  = 8'h24;

   localparam int CMD_W = 3;

   typedef enum logic [CMD_W-1:0] {
      CMD_PAGE_ON   = 3'd0,
      CMD_PAGE_OFF  = 3'd1,
      CMD_STALL_ON  = 3'd2,
      CMD_STALL_OFF = 3'd3,
      CMD_ZAP_ALL   = 3'd4,
      CMD_FAULT_ACK = 3'd5,
      CMD_HARD_RST  = 3'd6,
      CMD_NONE      = 3'd7
   } cmd_e;

   // interrupt bit positions
   localparam int IRQ_W      = 2;
   localparam int IRQ_FAULT  = 0;
   localparam int IRQ_BUSERR = 1;

   // status bit positions
   localparam int ST_PAGING  = 0;
   localparam int ST_FAULT   = 1;
   localparam int ST_STALL   = 2;
   localparam int ST_IDLE    = 3;
   localparam int ST_REPLAY  = 4;
   localparam int ST_FWRITE  = 5;
   localparam int ST_NOSTALL = 31;

endpackage

// File: rtl/iommu_cmd_seq.sv
module iommu_cmd_seq
   import iommu_ctl_pkg::*;
#(
   parameter int CMD_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_vld_i,
   input  cmd_e cmd_code_i,
   output logic paging_o,
   output logic stall_o,
   output logic hard_rst_o
);

   localparam int PIPE_BITS = CMD_W * CMD_LAT;

   logic [CMD_LAT-1:0]   stg_vld;
   logic [PIPE_BITS-1:0] stg_code;
   logic                 app_vld;
   cmd_e                 app_code;

   generate
      if (CMD_LAT == 1) begin : g_one_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_vld  <= '0;
               stg_code <= '0;
            end else begin
               stg_vld  <= cmd_vld_i;
               stg_code <= cmd_code_i;
            end
         end
      end else begin : g_shift_stages
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_vld  <= '0;
               stg_code <= '0;
            end else begin
               stg_vld  <= {stg_vld[CMD_LAT-2:0], cmd_vld_i};
               stg_code <= {stg_code[PIPE_BITS-CMD_W-1:0], cmd_code_i};
            end
         end
      end
   endgenerate

   assign app_vld  = stg_vld[CMD_LAT-1];
   assign app_code = cmd_e'(stg_code[PIPE_BITS-1 -: CMD_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paging_o <= 1'b0;
         stall_o  <= 1'b0;
      end else if (app_vld) begin
         case (app_code)
            CMD_PAGE_ON:   paging_o <= 1'b1;
            CMD_PAGE_OFF: begin
               paging_o <= 1'b0;
               stall_o  <= 1'b0;
            end
            CMD_STALL_ON:  if (paging_o) stall_o <= 1'b1;
            CMD_STALL_OFF: stall_o <= 1'b0;
            CMD_HARD_RST: begin
               paging_o <= 1'b0;
               stall_o  <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign hard_rst_o = app_vld && (app_code == CMD_HARD_RST);

endmodule

// File: rtl/iommu_irq_ctrl.sv
module iommu_irq_ctrl
   import iommu_ctl_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hard_rst_i,
   input  logic              fault_evt_i,
   input  logic              buserr_evt_i,
   input  logic              evt_write_i,
   input  logic [DATA_W-1:0] evt_addr_i,
   input  logic              mask_we_i,
   input  logic [IRQ_W-1:0]  mask_wd_i,
   input  logic              clr_we_i,
   input  logic [IRQ_W-1:0]  clr_wd_i,
   input  logic              ack_i,
   output logic [IRQ_W-1:0]  raw_o,
   output logic [IRQ_W-1:0]  mask_o,
   output logic              fault_act_o,
   output logic              fault_wr_o,
   output logic [DATA_W-1:0] fault_addr_o,
   output logic              irq_o
);

   logic [IRQ_W-1:0] evt;

   always_comb begin
      evt             = '0;
      evt[IRQ_FAULT]  = fault_evt_i;
      evt[IRQ_BUSERR] = buserr_evt_i;
   end

   generate
      for (genvar b = 0; b < IRQ_W; b++) begin : g_raw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   raw_o[b] <= 1'b0;
            else if (hard_rst_i)          raw_o[b] <= 1'b0;
            else if (evt[b])              raw_o[b] <= 1'b1;
            else if (clr_we_i && clr_wd_i[b]) raw_o[b] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o       <= '0;
         fault_act_o  <= 1'b0;
         fault_wr_o   <= 1'b0;
         fault_addr_o <= '0;
      end else if (hard_rst_i) begin
         mask_o       <= '0;
         fault_act_o  <= 1'b0;
         fault_wr_o   <= 1'b0;
         fault_addr_o <= '0;
      end else begin
         if (mask_we_i) mask_o <= mask_wd_i;
         if (fault_evt_i) begin
            fault_act_o <= 1'b1;
            fault_wr_o  <= evt_write_i;
         end else if (ack_i) begin
            fault_act_o <= 1'b0;
         end
         if (fault_evt_i || buserr_evt_i) fault_addr_o <= evt_addr_i;
      end
   end

   assign irq_o = |(raw_o & mask_o);

endmodule

// File: rtl/iommu_ctl_regs.sv
module iommu_ctl_regs
   import iommu_ctl_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int CMD_LAT    = 3,
   parameter int GATE_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              dp_fault_i,
   input  logic              dp_bus_err_i,
   input  logic              dp_fault_write_i,
   input  logic [DATA_W-1:0] dp_fault_addr_i,
   input  logic              dp_idle_i,
   input  logic              dp_replay_empty_i,
   output logic              paging_en_o,
   output logic              stall_en_o,
   output logic              zap_all_o,
   output logic              zap_line_o,
   output logic [DATA_W-1:0] zap_line_addr_o,
   output logic [GATE_W-1:0] gate_cfg_o,
   output logic              irq_o
);

   localparam int PG_BITS  = DATA_W - PAGE_SHIFT;
   localparam int CMD_LIM  = 7;

   // elaboration-time parameter checks
   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("DATA_W must be 32: status uses bit 31");
      end
      if (PAGE_SHIFT < 1 || PAGE_SHIFT >= DATA_W) begin : g_bad_page_shift
         $error("PAGE_SHIFT must lie between 1 and DATA_W-1");
      end
      if (CMD_LAT < 1 || CMD_LAT > 16) begin : g_bad_cmd_lat
         $error("CMD_LAT must lie between 1 and 16");
      end
      if (GATE_W < 1 || GATE_W > DATA_W) begin : g_bad_gate_w
         $error("GATE_W must lie between 1 and DATA_W");
      end
      if (ADDR_W < 6) begin : g_bad_addr_w
         $error("ADDR_W must cover offset 0x24");
      end
   endgenerate

   // write decode
   logic wr_base, wr_cmd, wr_zapln, wr_clr, wr_mask, wr_gate;

   assign wr_base  = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_BASE));
   assign wr_cmd   = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_CMD));
   assign wr_zapln = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_ZAPLN));
   assign wr_clr   = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_CLR));
   assign wr_mask  = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_MASK));
   assign wr_gate  = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_GATE));

   // command decode
   logic cmd_legal, cmd_timed, cmd_ack, cmd_zap;
   cmd_e cmd_code;

   assign cmd_legal = wr_cmd && (reg_wdata_i < DATA_W'(CMD_LIM));
   assign cmd_code  = cmd_e'(reg_wdata_i[CMD_W-1:0]);
   assign cmd_ack   = cmd_legal && (cmd_code == CMD_FAULT_ACK);
   assign cmd_zap   = cmd_legal && (cmd_code == CMD_ZAP_ALL);
   assign cmd_timed = cmd_legal && !cmd_ack && !cmd_zap;

   logic hard_rst;

   iommu_cmd_seq #(
      .CMD_LAT (CMD_LAT)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_vld_i  (cmd_timed),
      .cmd_code_i (cmd_code),
      .paging_o   (paging_en_o),
      .stall_o    (stall_en_o),
      .hard_rst_o (hard_rst)
   );

   logic [IRQ_W-1:0]  raw_w, mask_w;
   logic              fault_act_w, fault_wr_w;
   logic [DATA_W-1:0] fault_addr_w;

   iommu_irq_ctrl #(
      .DATA_W (DATA_W)
   ) u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .hard_rst_i   (hard_rst),
      .fault_evt_i  (dp_fault_i),
      .buserr_evt_i (dp_bus_err_i),
      .evt_write_i  (dp_fault_write_i),
      .evt_addr_i   (dp_fault_addr_i),
      .mask_we_i    (wr_mask),
      .mask_wd_i    (reg_wdata_i[IRQ_W-1:0]),
      .clr_we_i     (wr_clr),
      .clr_wd_i     (reg_wdata_i[IRQ_W-1:0]),
      .ack_i        (cmd_ack),
      .raw_o        (raw_w),
      .mask_o       (mask_w),
      .fault_act_o  (fault_act_w),
      .fault_wr_o   (fault_wr_w),
      .fault_addr_o (fault_addr_w),
      .irq_o        (irq_o)
   );

   // directory base, gating, flush pulses
   logic [PG_BITS-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q     <= '0;
         gate_cfg_o <= '0;
      end else if (hard_rst) begin
         base_q     <= '0;
         gate_cfg_o <= '0;
      end else begin
         if (wr_base) base_q     <= reg_wdata_i[DATA_W-1:PAGE_SHIFT];
         if (wr_gate) gate_cfg_o <= reg_wdata_i[GATE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zap_all_o       <= 1'b0;
         zap_line_o      <= 1'b0;
         zap_line_addr_o <= '0;
      end else begin
         zap_all_o  <= cmd_zap;
         zap_line_o <= wr_zapln;
         if (wr_zapln)
            zap_line_addr_o <= {reg_wdata_i[DATA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      end
   end

   // status word
   logic [DATA_W-1:0] stat_w;

   always_comb begin
      stat_w             = '0;
      stat_w[ST_PAGING]  = paging_en_o;
      stat_w[ST_FAULT]   = fault_act_w;
      stat_w[ST_STALL]   = stall_en_o;
      stat_w[ST_IDLE]    = dp_idle_i;
      stat_w[ST_REPLAY]  = dp_replay_empty_i;
      stat_w[ST_FWRITE]  = fault_wr_w;
      stat_w[ST_NOSTALL] = !stall_en_o;
   end

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         ADDR_W'(OFF_BASE):  reg_rdata_o = {base_q, {PAGE_SHIFT{1'b0}}};
         ADDR_W'(OFF_STAT):  reg_rdata_o = stat_w;
         ADDR_W'(OFF_FADDR): reg_rdata_o = fault_addr_w;
         ADDR_W'(OFF_RAW):   reg_rdata_o = DATA_W'(raw_w);
         ADDR_W'(OFF_MASK):  reg_rdata_o = DATA_W'(mask_w);
         ADDR_W'(OFF_MSTAT): reg_rdata_o = DATA_W'(raw_w & mask_w);
         ADDR_W'(OFF_GATE):  reg_rdata_o = DATA_W'(gate_cfg_o);
         default:            reg_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/iommu_ctl_regs_chk.sv
module iommu_ctl_regs_chk
   import iommu_ctl_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int PAGE_SHIFT = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              dp_fault_i,
   input logic              dp_bus_err_i,
   input logic              paging_en_o,
   input logic              stall_en_o,
   input logic              zap_all_o,
   input logic              zap_line_o,
   input logic              irq_o,
   input logic              fault_act
);

   // R4
   stall_needs_paging_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_en_o |-> paging_en_o);

   // R4
   stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_en_o) |-> $past(paging_en_o));

   // R2
   base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == ADDR_W'(OFF_BASE)) |-> (reg_rdata_o[PAGE_SHIFT-1:0] == '0));

   // R4
   stat_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == ADDR_W'(OFF_STAT)) |-> (reg_rdata_o[ST_NOSTALL] != reg_rdata_o[ST_STALL]));

   // R7
   fault_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dp_fault_i |=> fault_act);

   // R6
   zap_line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == ADDR_W'(OFF_ZAPLN)) |=> zap_line_o);

   // R5
   zap_all_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zap_all_o |-> $past(reg_wr_i));

   // R8
   irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(dp_fault_i || dp_bus_err_i || reg_wr_i));

endmodule

bind iommu_ctl_regs iommu_ctl_regs_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr_i     (reg_wr_i),
   .reg_addr_i   (reg_addr_i),
   .reg_rdata_o  (reg_rdata_o),
   .dp_fault_i   (dp_fault_i),
   .dp_bus_err_i (dp_bus_err_i),
   .paging_en_o  (paging_en_o),
   .stall_en_o   (stall_en_o),
   .zap_all_o    (zap_all_o),
   .zap_line_o   (zap_line_o),
   .irq_o        (irq_o),
   .fault_act    (fault_act_w)
);

// File: tb/iommu_ctl_regs_tb_top.sv
module iommu_ctl_regs_tb_top;

   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dp_fault = 1'b0, dp_bus_err = 1'b0, dp_fwrite = 1'b0;
   logic [31:0] dp_faddr = '0;
   logic        dp_idle = 1'b1, dp_replay = 1'b1;
   logic        paging, stall, zap_all, zap_line, irq;
   logic [31:0] zap_addr;
   logic [3:0]  gate;

   always #4 clk = ~clk;

   iommu_ctl_regs #(.CMD_LAT(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .dp_fault_i(dp_fault), .dp_bus_err_i(dp_bus_err),
      .dp_fault_write_i(dp_fwrite), .dp_fault_addr_i(dp_faddr),
      .dp_idle_i(dp_idle), .dp_replay_empty_i(dp_replay),
      .paging_en_o(paging), .stall_en_o(stall), .zap_all_o(zap_all),
      .zap_line_o(zap_line), .zap_line_addr_o(zap_addr),
      .gate_cfg_o(gate), .irq_o(irq));

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   function automatic logic [31:0] pick(int sel);
      case (sel)
         0: return reg_rdata;
         1: return {31'b0, irq};
         2: return {31'b0, zap_all};
         3: return {31'b0, zap_line};
         4: return zap_addr;
         5: return {31'b0, paging};
         6: return {31'b0, stall};
         default: return {28'b0, gate};
      endcase
   endfunction

   // monitor: pops expected items and compares them
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = pick(it.sel);
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(int sel, logic [31:0] exp, string tag);
      item_t it;
      it.sel = sel; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      reg_addr = a;
      push(0, exp, tag);
      @(negedge clk);
   endtask

   task automatic cmd(logic [31:0] c);
      wr(8'h08, c);
      idle(LAT);
   endtask

   task automatic pulse_evt(bit fault, bit buserr, bit wdir, logic [31:0] a);
      dp_fault = fault; dp_bus_err = buserr; dp_fwrite = wdir; dp_faddr = a;
      @(negedge clk);
      dp_fault = 1'b0; dp_bus_err = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // reset state
      rd(8'h00, 32'h0, "R1 base after reset");
      rd(8'h04, 32'h8000_0018, "R12 status after reset");
      rd(8'h14, 32'h0, "R1 raw after reset");
      push(1, 0, "R8 irq after reset");
      push(5, 0, "R3 paging after reset");

      // base masking
      wr(8'h00, 32'hCAFE_BABE);
      rd(8'h00, 32'hCAFE_B000, "R2 base CAFEBABE");
      wr(8'h00, 32'h1234_5FFF);
      rd(8'h00, 32'h1234_5000, "R2 base low bits");

      // stall without paging
      cmd(2);
      push(6, 0, "R4 stall needs paging");
      rd(8'h04, 32'h8000_0018, "R4 status no stall");

      // exact paging latency
      wr(8'h08, 0);
      push(5, 0, "R3 paging before latency");
      idle(LAT - 1);
      push(5, 0, "R3 paging one edge early");
      idle(1);
      push(5, 1, "R3 paging on at latency");
      rd(8'h04, 32'h8000_0019, "R3 status paging");

      // stall on / off
      cmd(2);
      push(6, 1, "R4 stall on");
      rd(8'h04, 32'h0000_001D, "R4 status stall, bit31 low");
      cmd(3);
      rd(8'h04, 32'h8000_0019, "R4 stall off");
      cmd(2);
      cmd(1);
      push(6, 0, "R4 paging off drops stall");
      push(5, 0, "R3 paging off");
      rd(8'h04, 32'h8000_0018, "R4 status after paging off");
      cmd(0);

      // flush all
      wr(8'h08, 4);
      push(2, 1, "R5 zap all pulse");
      idle(1);
      push(2, 0, "R5 zap all one cycle");

      // flush one line
      wr(8'h10, 32'hABCD_E123);
      push(3, 1, "R6 zap line pulse");
      push(4, 32'hABCD_E000, "R6 zap line address");
      idle(1);
      push(3, 0, "R6 zap line one cycle");

      // page fault
      pulse_evt(1, 0, 1, 32'h0040_1234);
      rd(8'h14, 32'h1, "R7 raw fault bit");
      rd(8'h04, 32'h8000_003B, "R7 status fault active write");
      rd(8'h0C, 32'h0040_1234, "R7 fault address");
      rd(8'h20, 32'h0, "R8 masked with zero mask");
      push(1, 0, "R8 irq masked");
      wr(8'h1C, 32'h3);
      push(1, 1, "R8 irq after mask");
      rd(8'h20, 32'h1, "R8 masked fault");

      // bus error
      pulse_evt(0, 1, 0, 32'h0000_BEEF);
      rd(8'h14, 32'h3, "R7 raw both bits");
      rd(8'h0C, 32'h0000_BEEF, "R7 bus error address");
      rd(8'h04, 32'h8000_003B, "R7 bus error keeps direction");
      rd(8'h20, 32'h3, "R8 masked both");

      // clear
      wr(8'h18, 32'h2);
      rd(8'h14, 32'h1, "R9 clear bus error bit");
      wr(8'h18, 32'h1);
      rd(8'h14, 32'h0, "R9 clear fault bit");
      push(1, 0, "R8 irq low after clear");

      // clear and event in the same cycle
      dp_fault = 1'b1; dp_fwrite = 1'b0; dp_faddr = 32'h0000_2000;
      wr(8'h18, 32'h1);
      dp_fault = 1'b0;
      rd(8'h14, 32'h1, "R9 event beats clear");
      push(1, 1, "R8 irq after event");

      // fault acknowledge
      wr(8'h08, 5);
      rd(8'h04, 32'h8000_0019, "R10 ack clears fault active");
      rd(8'h14, 32'h1, "R10 ack keeps raw");
      dp_fault = 1'b1;
      wr(8'h08, 5);
      dp_fault = 1'b0;
      rd(8'h04, 32'h8000_001B, "R10 event beats ack");

      // gating
      wr(8'h24, 32'hFFFF_FFFF);
      rd(8'h24, 32'h0000_000F, "R13 gating readback");
      push(7, 32'hF, "R13 gating output");

      // ignored commands and dead offsets
      rd(8'h08, 32'h0, "R12 command reads zero");
      rd(8'h3C, 32'h0, "R12 unmapped reads zero");
      dp_idle = 1'b0; dp_replay = 1'b0;
      rd(8'h04, 32'h8000_0003, "R12 status mirrors datapath");
      dp_idle = 1'b1; dp_replay = 1'b1;
      cmd(7);
      cmd(32'h0000_0101);
      push(5, 1, "R12 illegal commands ignored");
      rd(8'h04, 32'h8000_001B, "R12 status unchanged");

      // force reset
      wr(8'h00, 32'hCAFE_BABE);
      cmd(2);
      push(6, 1, "R11 stall before reset");
      cmd(6);
      rd(8'h00, 32'h0, "R11 base cleared");
      rd(8'h04, 32'h8000_0018, "R11 status cleared");
      rd(8'h14, 32'h0, "R11 raw cleared");
      rd(8'h1C, 32'h0, "R11 mask cleared");
      rd(8'h0C, 32'h0, "R11 fault address cleared");
      rd(8'h24, 32'h0, "R11 gating cleared");
      push(5, 0, "R11 paging off");
      push(6, 0, "R11 stall off");
      push(1, 0, "R11 irq low");

      idle(2);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule